// File: doc/BRIEF.md
# Dual-Channel Compare Match Interval Timer

This block is a peripheral interval timer with two independent channels and no external pins. Each channel divides the peripheral clock down to a count-enable pulse using its own prescaler. On each pulse it advances a 16-bit up-counter. When a count pulse arrives while the counter already equals the channel's compare value, the channel enters a clear phase. On the next clock the counter returns to zero and the channel emits a one-cycle event toward an interrupt controller. The event is gated by the channel's interrupt-enable bit. The resulting event period is (compare + 1) count periods.

Software reaches every register through a simple single-cycle register bus. A shared run register holds one bit per channel. Each channel has a control, a counter and a compare register. A bus write that lands on the counter also starts a compare, even when the channel is halted. A write to the counter loses against the clear phase but wins against a coincident count pulse.

Each channel is sequenced by a three-state machine:
- `CH_STOP`: halted.
- `CH_RUN`: counting.
- `CH_CLEAR`: one cycle, match taken, counter about to be zeroed.

The transitions are:
- `STOP->RUN` when the run bit is set.
- `RUN->STOP` when the run bit is cleared.
- `STOP->CLEAR` on an equality caused by a write.
- `RUN->CLEAR` on a count pulse at equality, or on an equality caused by a write.
- `CLEAR->RUN` or `CLEAR->STOP` after one cycle, according to the run bit.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every counter reads 0x0000, every compare register reads 0xFFFF, every control register and the run register read 0, and both event outputs are low.
- R2: Register map (word addresses): 0 = run register, with bit n running channel n. Channel n uses address 4(n+1) for control, 4(n+1)+1 for the counter and 4(n+1)+2 for compare. In the control register, bits [1:0] are the clock select and bit 2 is the interrupt enable. Reads are combinational from `bus_addr`.
- R3: Clock select values 0, 1, 2 and 3 give a count pulse every 8, 32, 128 and 512 clocks. The first pulse moves the counter at the edge that lies one full ratio after the edge that wrote the run bit to 1.
- R4: With the run bit written to 1 at edge S, the counter starting at 0 and the enable set, the event is high in the cycle after edge S + k*(compare+1)*ratio + 1, for k = 1, 2, and so on.
- R5: The event is high for exactly one cycle, and the counter reads 0 in that cycle.
- R6: A counter write at the same edge as the clear phase is discarded, and the counter becomes 0.
- R7: A counter write at the same edge as a count pulse loads the written value, and that pulse's increment is dropped.
- R8: A write that makes the counter equal the compare value triggers a match even when the channel is halted. The counter reads 0 and, if enabled, the event is high after the second edge following the write.
- R9: With the enable bit at 0, no event is produced, but the counter is still cleared on a match.
- R10: Clearing a run bit freezes that counter and resets the prescaler phase. A restart resumes counting from the frozen value, with a full ratio before the first pulse.
- R11: The two channels count, match and raise events independently, each with its own clock select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 2 | One-cycle compare-match events, one per channel |

## Verification
A run-bit write at edge S makes the first count pulse act at edge S + ratio. A match pulse acting at edge M puts the channel in the clear phase after M, and the event and the zeroed counter follow edge M + 1. A write that creates equality at edge W therefore produces its event after edge W + 2.

The driver tasks return the number of the edge at which each write landed. Every expected event edge is computed from that number and queued, and a monitor compares `irq` at each falling edge against the queue heads. Collision writes are placed on exactly the computed count-pulse or clear edge, and register reads are sampled at the falling edge after the edge being checked.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [1:0] {
        CH_STOP  = 2'd0,
        CH_RUN   = 2'd1,
        CH_CLEAR = 2'd2
    } ch_state_e;

endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
    parameter int CKS_W         = 2,
    parameter int DIV_MIN_LOG2  = 3,
    parameter int DIV_STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    localparam int NSEL   = 1 << CKS_W;
    localparam int PCNT_W = DIV_MIN_LOG2 + DIV_STEP_LOG2 * (NSEL - 1);

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] last_val;

    // terminal phase value for each ratio: ratio - 1
    always_comb begin
        last_val = '0;
        for (int s = 0; s < NSEL; s++) begin
            if (cks == CKS_W'(s))
                last_val = PCNT_W'((1 << (DIV_MIN_LOG2 + DIV_STEP_LOG2 * s)) - 1);
        end
    end

    // >= keeps the pulse alive if the ratio shrinks mid-period
    assign tick = run && (pcnt_q >= last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (!run || tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end

endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel
    import mtmr_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int CKS_W         = 2,
    parameter int DIV_MIN_LOG2  = 3,
    parameter int DIV_STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_ctrl,
    input  logic             wr_cnt,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    output logic [CKS_W-1:0] cks_o,
    output logic             ie_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             clr_o,
    output logic             irq_o
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cmp_q;
    logic [CKS_W-1:0] cks_q;
    logic             ie_q;
    logic             irq_q;
    logic             touch_q;
    logic             tick;
    logic             equal;
    logic             match_go;

    mtmr_prescaler #(
        .CKS_W        (CKS_W),
        .DIV_MIN_LOG2 (DIV_MIN_LOG2),
        .DIV_STEP_LOG2(DIV_STEP_LOG2)
    ) presc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .cks  (cks_q),
        .tick (tick)
    );

    assign equal = (cnt_q == cmp_q);

    // a match comes from a count pulse at equality, or from an equality
    // created by a write one cycle earlier; a counter write this cycle wins
    always_comb begin
        match_go = 1'b0;
        if (state_q != CH_CLEAR && !wr_cnt && equal) begin
            if (touch_q || (state_q == CH_RUN && tick))
                match_go = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_STOP;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP:  state_d = match_go ? CH_CLEAR : (run ? CH_RUN : CH_STOP);
            CH_RUN:   state_d = match_go ? CH_CLEAR : (run ? CH_RUN : CH_STOP);
            CH_CLEAR: state_d = run ? CH_RUN : CH_STOP;
            default:  state_d = CH_STOP;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_q   <= '1;
            cks_q   <= '0;
            ie_q    <= 1'b0;
            irq_q   <= 1'b0;
            touch_q <= 1'b0;
        end else begin
            irq_q   <= (state_q == CH_CLEAR) && ie_q;
            touch_q <= wr_cmp || (wr_cnt && state_q != CH_CLEAR);
            if (wr_ctrl) begin
                cks_q <= wdata[CKS_W-1:0];
                ie_q  <= wdata[CKS_W];
            end
            if (wr_cmp)
                cmp_q <= wdata;
            unique case (state_q)
                CH_CLEAR: cnt_q <= '0;
                CH_RUN: begin
                    if (wr_cnt)
                        cnt_q <= wdata;
                    else if (tick && !match_go)
                        cnt_q <= cnt_q + 1'b1;
                end
                CH_STOP: begin
                    if (wr_cnt)
                        cnt_q <= wdata;
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cks_o = cks_q;
    assign ie_o  = ie_q;
    assign cnt_o = cnt_q;
    assign cmp_o = cmp_q;
    assign clr_o = (state_q == CH_CLEAR);
    assign irq_o = irq_q;

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer #(
    parameter int NCH           = 2,
    parameter int CNT_W         = 16,
    parameter int ADDR_W        = 4,
    parameter int CKS_W         = 2,
    parameter int DIV_MIN_LOG2  = 3,
    parameter int DIV_STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq
);
    localparam int CH_STRIDE = 4;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_CNT   = 1;
    localparam int OFS_CMP   = 2;

    logic [NCH-1:0]              start_q;
    logic [NCH-1:0]              ch_clr;
    logic [NCH-1:0]              ch_ie;
    logic [NCH-1:0]              ch_cnt_wr;
    logic [NCH-1:0][CNT_W-1:0]   ch_cnt;
    logic [NCH-1:0][CNT_W-1:0]   ch_cmp;
    logic [NCH-1:0][CKS_W-1:0]   ch_cks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            start_q <= '0;
        else if (bus_wr && bus_addr == '0)
            start_q <= bus_wdata[NCH-1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int BASE = CH_STRIDE * (g + 1);
        logic wr_ctrl, wr_cmp;

        assign wr_ctrl      = bus_wr && bus_addr == ADDR_W'(BASE + OFS_CTRL);
        assign ch_cnt_wr[g] = bus_wr && bus_addr == ADDR_W'(BASE + OFS_CNT);
        assign wr_cmp       = bus_wr && bus_addr == ADDR_W'(BASE + OFS_CMP);

        mtmr_channel #(
            .CNT_W        (CNT_W),
            .CKS_W        (CKS_W),
            .DIV_MIN_LOG2 (DIV_MIN_LOG2),
            .DIV_STEP_LOG2(DIV_STEP_LOG2)
        ) ch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (start_q[g]),
            .wr_ctrl(wr_ctrl),
            .wr_cnt (ch_cnt_wr[g]),
            .wr_cmp (wr_cmp),
            .wdata  (bus_wdata),
            .cks_o  (ch_cks[g]),
            .ie_o   (ch_ie[g]),
            .cnt_o  (ch_cnt[g]),
            .cmp_o  (ch_cmp[g]),
            .clr_o  (ch_clr[g]),
            .irq_o  (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0)
            bus_rdata = CNT_W'(start_q);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(CH_STRIDE * (i + 1) + OFS_CTRL))
                bus_rdata = CNT_W'({ch_ie[i], ch_cks[i]});
            if (bus_addr == ADDR_W'(CH_STRIDE * (i + 1) + OFS_CNT))
                bus_rdata = ch_cnt[i];
            if (bus_addr == ADDR_W'(CH_STRIDE * (i + 1) + OFS_CMP))
                bus_rdata = ch_cmp[i];
        end
    end

endmodule

// File: rtl/dual_match_timer_chk.sv
module dual_match_timer_chk #(
    parameter int NCH   = 2,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            start_q,
    input logic [NCH-1:0]            ch_clr,
    input logic [NCH-1:0]            ch_ie,
    input logic [NCH-1:0]            ch_cnt_wr,
    input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NCH-1:0]            irq,
    input logic [CNT_W-1:0]          bus_wdata
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R5
        irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |=> !irq[g]);
        // R5
        irq_zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> ch_cnt[g] == '0);
        // R9
        irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(ch_ie[g]));
        // R6
        clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_clr[g] |=> ch_cnt[g] == '0);
        // R7
        write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_cnt_wr[g] && !ch_clr[g]) |=> ch_cnt[g] == $past(bus_wdata));
        // R10
        frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!start_q[g] && !ch_cnt_wr[g] && !ch_clr[g]) |=> $stable(ch_cnt[g]));
    end
endmodule

bind dual_match_timer dual_match_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_q  (start_q),
    .ch_clr   (ch_clr),
    .ch_ie    (ch_ie),
    .ch_cnt_wr(ch_cnt_wr),
    .ch_cnt   (ch_cnt),
    .irq      (irq),
    .bus_wdata(bus_wdata)
);

// File: tb/dual_match_timer_tb_top.sv
`timescale 1ns/1ps
module dual_match_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_q0[$];
    int exp_q1[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_match_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d, output int edge_n);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        edge_n = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic write_at(input logic [3:0] a, input logic [15:0] d, input int target);
        @(negedge clk);
        while (cyc < target - 1) @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        check("R7/R6 write edge placement", cyc, target);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares irq against queued expected event edges
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e0, e1;
            e0 = (exp_q0.size() > 0) && (exp_q0[0] == cyc);
            e1 = (exp_q1.size() > 0) && (exp_q1[0] == cyc);
            if (e0) void'(exp_q0.pop_front());
            if (e1) void'(exp_q1.pop_front());
            if (e0 || irq[0]) check("R4/R5/R9 ch0 event", int'(irq[0]), int'(e0));
            if (e1 || irq[1]) check("R4/R11 ch1 event", int'(irq[1]), int'(e1));
        end
    end

    initial begin
        #(4.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int s, w, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 irq", int'(irq), 0);
        bus_read(4'd0, v);  check("R1 run reg", v, 0);
        bus_read(4'd5, v);  check("R1 cnt0", v, 0);
        bus_read(4'd6, v);  check("R1 cmp0", v, 16'hFFFF);
        bus_read(4'd10, v); check("R1 cmp1", v, 16'hFFFF);
        bus_read(4'd8, v);  check("R1 ctrl1", v, 0);

        // R2 R4 ch0: div 8, compare 3, enabled
        bus_write(4'd4, 16'h0004, w);
        bus_write(4'd6, 16'd3, w);
        bus_read(4'd4, v); check("R2 ctrl0 readback", v, 4);
        bus_read(4'd6, v); check("R2 cmp0 readback", v, 3);
        bus_write(4'd0, 16'd1, s);
        exp_q0.push_back(s + 33);
        exp_q0.push_back(s + 65);
        // R10 stop after 10 pulses: count = 10 mod 4 = 2
        write_at(4'd0, 16'd0, s + 83);
        bus_read(4'd5, v); check("R10 frozen count", v, 2);
        idle(40);
        bus_read(4'd5, v); check("R10 count still frozen", v, 2);

        // R10 restart phase + R6 write during clear phase
        bus_write(4'd0, 16'd1, s);
        exp_q0.push_back(s + 17);
        write_at(4'd5, 16'd9, s + 17);
        bus_read(4'd5, v); check("R6 write discarded on clear", v, 0);
        bus_write(4'd0, 16'd0, w);

        // R7 ch1 write on count pulse
        bus_write(4'd8, 16'h0004, w);
        bus_write(4'd10, 16'd100, w);
        bus_write(4'd0, 16'd2, s);
        write_at(4'd9, 16'd50, s + 16);
        bus_read(4'd9, v); check("R7 load wins over pulse", v, 50);
        bus_write(4'd0, 16'd0, w);

        // R8 equal write while stopped
        bus_write(4'd5, 16'd3, w);
        exp_q0.push_back(w + 2);
        idle(4);
        bus_read(4'd5, v); check("R8 cleared after equal write", v, 0);
        bus_read(4'd0, v); check("R8 still stopped", v, 0);

        // R9 enable off: no event, counter still cleared
        bus_write(4'd4, 16'h0000, w);
        bus_write(4'd5, 16'd3, w);
        idle(10);
        bus_read(4'd5, v); check("R9 cleared without event", v, 0);

        // R3 R11 both channels: ch0 div 32 compare 0, ch1 div 512 compare 1
        bus_write(4'd6, 16'd0, w);   // equality with ie=0: silent clear
        idle(4);
        bus_write(4'd4, 16'h0005, w);
        bus_write(4'd8, 16'h0007, w);
        bus_write(4'd9, 16'd0, w);
        bus_write(4'd10, 16'd1, w);
        idle(4);
        bus_write(4'd0, 16'd3, s);
        for (int k = 1; k <= 64; k++) exp_q0.push_back(s + 32 * k + 1);
        exp_q1.push_back(s + 1025);
        exp_q1.push_back(s + 2049);
        write_at(4'd0, 16'd0, s + 2060);
        idle(20);
        check("R4 all ch0 events seen", exp_q0.size(), 0);
        check("R11 all ch1 events seen", exp_q1.size(), 0);
        bus_read(4'd9, v); check("R3 ch1 count after 4 pulses", v, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule